// File: doc/BRIEF.md
# Trap Restart Point Selector

This block sits beside an in-order pipeline and decides where execution resumes when an exception is taken. Each cycle it sees which pipeline slots hold live instructions, their PCs and lengths in words. It also sees three kinds of event: a software trap or system call from EX1, a memory fault (TLB miss or protection fault) from EX2, and a control redirect target. From these it picks the restart stage and the restart PC. One cycle later it emits a single-cycle take pulse with the restart PC, a cause code and a flush mask.

Stages are indexed from youngest (0, fetch) to oldest. With the defaults, index 2 is EX1, index 3 is EX2, and indices 4 and 5 are EX3 and writeback. The two oldest stages hold instructions that have already produced results. They are never chosen as a restart point and never flushed.

If a memory fault is raised while the EX2 slot is a bubble or a flushed entry, the block walks toward younger stages and restarts from the first live slot it finds. This happens, for example, with a fault tied to a branch target. A redirect whose target falls strictly inside a live multi-word instruction is reported as a fault of its own.

Top module: `trap_restart_sel`

## Requirements
- R1: While reset is held and in the first cycle after it, `take_o` is 0, `flush_o` is all zeros, `cause_o` is 0 and `restart_pc_o` is 0.
- R2: A software trap request (`sw_trap_req`) with the EX1 slot live makes the next cycle show `take_o`=1, `restart_pc_o` = EX1 PC and `flush_o` = bits 0..EX1 set. `cause_o` is 1 for a plain trap (`sw_trap_is_call`=0) and 2 for a system call.
- R3: A software trap request while the EX1 slot is not live is ignored: `take_o` stays 0 the next cycle.
- R4: A memory fault (`mem_fault_req`) with the EX2 slot live restarts at the EX2 PC and flushes bits 0..EX2. `cause_o` is 3 when `mem_fault_kind`=0 (TLB miss) and 4 when it is 1 (protection).
- R5: A memory fault with EX2 not live restarts at the live slot nearest to EX2 among EX1 and the younger stages, and flushes that slot and every younger one.
- R6: A memory fault with no live slot at or below EX2 restarts at `fetch_pc` and flushes bits 0..EX2.
- R7: The flush mask never has a bit set for a stage older than EX2, and `flush_o` is always a contiguous run of ones starting at bit 0.
- R8: A redirect (`redir_req`) whose target T satisfies P < T < P + 4·L for some live slot with PC P and length L words gives `cause_o`=5, `restart_pc_o`=T and `flush_o` = bits 0..EX1.
- R9: A redirect whose target equals a live slot's start address or its end address P + 4·L, or lies outside every live span, causes no take.
- R10: When events coincide, the oldest source wins: memory fault (EX2) over redirect fault, and redirect fault over software trap.
- R11: Outputs are registered: each request cycle gives exactly one cycle of result, and when `take_o` is 0, `flush_o` and `cause_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stg_vld | input | NSTG | Bit i set when stage i holds a live instruction |
| stg_pc | input | NSTG*PCW | PC of stage i at bits [i*PCW +: PCW] |
| stg_len | input | NSTG*LENW | Length in words of stage i's instruction |
| sw_trap_req | input | 1 | Software trap raised in EX1 |
| sw_trap_is_call | input | 1 | 1 = system call, 0 = plain trap |
| mem_fault_req | input | 1 | Memory fault raised in EX2 |
| mem_fault_kind | input | 1 | 0 = TLB miss, 1 = protection fault |
| fetch_pc | input | PCW | Restart PC used when no live slot exists |
| redir_req | input | 1 | A control redirect is being issued |
| redir_pc | input | PCW | Redirect target address |
| take_o | output | 1 | One-cycle pulse: trap taken |
| restart_pc_o | output | PCW | Restart address |
| cause_o | output | 3 | Cause code (1..5, 0 when idle) |
| flush_o | output | NSTG | Stages to flush this cycle |

## Verification
The bench aims at the fallback walk. It clears EX2 alone, clears EX2 and EX1, and leaves only the fetch slot live. A design that searched in the wrong direction, or counted EX3 as a candidate, would restart from an older slot and flush stages that already finished. For redirect targets it hits exactly the start, one word in and exactly the end address of multi-word instructions. An off-by-one bound would either fault on a legal branch or miss a landing in the middle of an instruction. Coincident requests test the priority order, and a trap raised over a bubble in EX1 must produce no take at all.

// File: rtl/trs_pkg.sv
package trs_pkg;
  typedef enum logic [2:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_TRAP    = 3'd1,
    CAUSE_SYSCALL = 3'd2,
    CAUSE_TLBMISS = 3'd3,
    CAUSE_PROT    = 3'd4,
    CAUSE_MIDINSN = 3'd5
  } cause_e;

  function automatic cause_e sw_cause(input logic is_call);
    return is_call ? CAUSE_SYSCALL : CAUSE_TRAP;
  endfunction

  function automatic cause_e mem_cause(input logic kind);
    return kind ? CAUSE_PROT : CAUSE_TLBMISS;
  endfunction
endpackage

// File: rtl/trs_span_check.sv
module trs_span_check #(
  parameter int NSTG = 6,
  parameter int PCW  = 32,
  parameter int LENW = 2,
  parameter int WSH  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSTG-1:0]      live,
  input  logic [NSTG*PCW-1:0]  pcs,
  input  logic [NSTG*LENW-1:0] lens,
  input  logic                 req,
  input  logic [PCW-1:0]       tgt,
  output logic [NSTG-1:0]      hit_vec,
  output logic                 hit_any
);
  localparam int EW = PCW + 1;

  // Strictly inside (base, base + len words); computed one bit wider to avoid wrap.
  function automatic logic inside_span(input logic [PCW-1:0] base,
                                       input logic [LENW-1:0] len,
                                       input logic [PCW-1:0] t);
    logic [EW-1:0] lo, hi, tw;
    lo = {1'b0, base};
    hi = lo + (EW'(len) << WSH);
    tw = {1'b0, t};
    return (tw > lo) && (tw < hi);
  endfunction

  genvar g;
  generate
    for (g = 0; g < NSTG; g++) begin : g_span
      assign hit_vec[g] = req && live[g] &&
                          inside_span(pcs[g*PCW +: PCW], lens[g*LENW +: LENW], tgt);
    end
  endgenerate

  assign hit_any = |hit_vec;

  // R8: a landing fault is only ever flagged for an actual redirect
  assert_hit_needs_redirect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any |-> req);
  // R8: a flagged slot must be live
  assert_hit_on_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec & ~live) == '0);
endmodule

// File: rtl/trs_slot_search.sv
module trs_slot_search #(
  parameter int NSTG  = 6,
  parameter int LIMIT = 3,
  parameter int SELW  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSTG-1:0] live,
  output logic            found,
  output logic [SELW-1:0] idx
);
  // Ascending scan keeps the last live hit, i.e. the one closest to LIMIT.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i <= LIMIT; i++) begin
      if (live[i]) begin
        found = 1'b1;
        idx   = SELW'(i);
      end
    end
  end

  // R5: the chosen slot holds a live instruction
  assert_pick_is_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> live[idx]);
  // R7: the pick never lands above the search limit
  assert_pick_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (int'(idx) <= LIMIT));
  // R6: nothing found means no live slot up to the limit
  assert_none_means_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !found |-> ((live & NSTG'((1 << (LIMIT + 1)) - 1)) == '0));
endmodule

// File: rtl/trap_restart_sel.sv
module trap_restart_sel #(
  parameter int NSTG    = 6,
  parameter int EX1_IDX = 2,
  parameter int EX2_IDX = 3,
  parameter int PCW     = 32,
  parameter int LENW    = 2,
  parameter int WSH     = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSTG-1:0]      stg_vld,
  input  logic [NSTG*PCW-1:0]  stg_pc,
  input  logic [NSTG*LENW-1:0] stg_len,
  input  logic                 sw_trap_req,
  input  logic                 sw_trap_is_call,
  input  logic                 mem_fault_req,
  input  logic                 mem_fault_kind,
  input  logic [PCW-1:0]       fetch_pc,
  input  logic                 redir_req,
  input  logic [PCW-1:0]       redir_pc,
  output logic                 take_o,
  output logic [PCW-1:0]       restart_pc_o,
  output logic [2:0]           cause_o,
  output logic [NSTG-1:0]      flush_o
);
  import trs_pkg::*;

  localparam int SELW = (NSTG > 1) ? $clog2(NSTG) : 1;

  // Mask with bits 0..idx set: that slot plus every younger one.
  function automatic logic [NSTG-1:0] upto_mask(input int idx);
    logic [NSTG-1:0] m;
    for (int i = 0; i < NSTG; i++) m[i] = (i <= idx);
    return m;
  endfunction

  // Named internal events
  logic            mid_fault;
  logic [NSTG-1:0] mid_vec;
  logic            srch_found;
  logic [SELW-1:0] srch_idx;
  logic            sw_event;
  logic            mem_event;
  logic [PCW-1:0]  ex1_pc;
  logic [PCW-1:0]  ex2_pc;
  logic [PCW-1:0]  srch_pc;

  assign ex1_pc    = stg_pc[EX1_IDX*PCW +: PCW];
  assign ex2_pc    = stg_pc[EX2_IDX*PCW +: PCW];
  assign srch_pc   = stg_pc[int'(srch_idx)*PCW +: PCW];
  assign sw_event  = sw_trap_req && stg_vld[EX1_IDX];
  assign mem_event = mem_fault_req;

  trs_span_check #(.NSTG(NSTG), .PCW(PCW), .LENW(LENW), .WSH(WSH)) u_span (
    .clk     (clk),
    .rst_n   (rst_n),
    .live    (stg_vld),
    .pcs     (stg_pc),
    .lens    (stg_len),
    .req     (redir_req),
    .tgt     (redir_pc),
    .hit_vec (mid_vec),
    .hit_any (mid_fault)
  );

  trs_slot_search #(.NSTG(NSTG), .LIMIT(EX2_IDX), .SELW(SELW)) u_search (
    .clk   (clk),
    .rst_n (rst_n),
    .live  (stg_vld),
    .found (srch_found),
    .idx   (srch_idx)
  );

  // Priority: oldest source first
  logic            take_d;
  logic [PCW-1:0]  pc_d;
  cause_e          cause_d;
  logic [NSTG-1:0] flush_d;

  always_comb begin
    take_d  = 1'b0;
    pc_d    = '0;
    cause_d = CAUSE_NONE;
    flush_d = '0;
    if (mem_event) begin
      take_d  = 1'b1;
      cause_d = mem_cause(mem_fault_kind);
      if (srch_found) begin
        pc_d    = srch_pc;
        flush_d = upto_mask(int'(srch_idx));
      end else begin
        pc_d    = fetch_pc;
        flush_d = upto_mask(EX2_IDX);
      end
    end else if (mid_fault) begin
      take_d  = 1'b1;
      cause_d = CAUSE_MIDINSN;
      pc_d    = redir_pc;
      flush_d = upto_mask(EX1_IDX);
    end else if (sw_event) begin
      take_d  = 1'b1;
      cause_d = sw_cause(sw_trap_is_call);
      pc_d    = ex1_pc;
      flush_d = upto_mask(EX1_IDX);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_o       <= 1'b0;
      restart_pc_o <= '0;
      cause_o      <= 3'd0;
      flush_o      <= '0;
    end else begin
      take_o       <= take_d;
      restart_pc_o <= pc_d;
      cause_o      <= 3'(cause_d);
      flush_o      <= flush_d;
    end
  end

  // R2: software trap with live EX1 and nothing older pending
  assert_sw_trap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_trap_req && stg_vld[EX1_IDX] && !mem_fault_req && !mid_fault)
      |=> take_o && (restart_pc_o == $past(ex1_pc)) && (cause_o inside {3'd1, 3'd2}));
  // R3: software trap over a bubble is dropped
  assert_sw_bubble_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_trap_req && !stg_vld[EX1_IDX] && !mem_fault_req && !mid_fault) |=> !take_o);
  // R4: memory fault with live EX2 restarts there
  assert_mem_ex2_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_fault_req && stg_vld[EX2_IDX])
      |=> take_o && (restart_pc_o == $past(ex2_pc)) && (cause_o inside {3'd3, 3'd4}));
  // R8: landing inside an instruction reports the target address
  assert_mid_landing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_fault && !mem_fault_req)
      |=> take_o && (cause_o == 3'd5) && (restart_pc_o == $past(redir_pc)));
  // R7: completed stages are never flushed; mask is a run from bit 0
  assert_old_stages_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((flush_o >> (EX2_IDX + 1)) == '0) && ((flush_o & (flush_o + 1'b1)) == '0));
  // R11: idle cycles are quiet
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> (flush_o == '0) && (cause_o == 3'd0));
  // R11: no event, no take
  assert_no_event_no_take_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_fault_req && !redir_req && !sw_trap_req) |=> !take_o);
endmodule

// File: tb/sim_trap_restart_sel.sv
module sim_trap_restart_sel;
  localparam int NSTG = 6, EX1 = 2, EX2 = 3, PCW = 32, LENW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSTG-1:0]      vld = '0;
  logic [NSTG*PCW-1:0]  pcs = '0;
  logic [NSTG*LENW-1:0] lens = '0;
  logic sw_req = 0, sw_call = 0, mf_req = 0, mf_kind = 0, rd_req = 0;
  logic [PCW-1:0] fpc = '0, rd_pc = '0;
  logic            take;
  logic [PCW-1:0]  rpc;
  logic [2:0]      cause;
  logic [NSTG-1:0] flush;

  int total = 0, bad = 0;

  always #2 clk = ~clk;

  trap_restart_sel u0 (
    .clk(clk), .rst_n(rst_n), .stg_vld(vld), .stg_pc(pcs), .stg_len(lens),
    .sw_trap_req(sw_req), .sw_trap_is_call(sw_call),
    .mem_fault_req(mf_req), .mem_fault_kind(mf_kind), .fetch_pc(fpc),
    .redir_req(rd_req), .redir_pc(rd_pc),
    .take_o(take), .restart_pc_o(rpc), .cause_o(cause), .flush_o(flush)
  );

  function automatic logic [NSTG-1:0] low_ones(input int n);
    return NSTG'((1 << n) - 1);
  endfunction

  function automatic logic [PCW-1:0] pc_of(input int i);
    return pcs[i*PCW +: PCW];
  endfunction

  // Landing fault per R8/R9 boundaries
  function automatic logic lands_mid();
    for (int i = 0; i < NSTG; i++) begin
      longint lo = longint'(pcs[i*PCW +: PCW]);
      longint hi = lo + 4 * longint'(lens[i*LENW +: LENW]);
      longint t  = longint'(rd_pc);
      if (rd_req && vld[i] && t > lo && t < hi) return 1'b1;
    end
    return 1'b0;
  endfunction

  logic            e_take;
  logic [PCW-1:0]  e_pc;
  logic [2:0]      e_cause;
  logic [NSTG-1:0] e_flush;

  task automatic predict();
    e_take = 0; e_pc = '0; e_cause = 0; e_flush = '0;
    if (mf_req) begin
      e_take = 1; e_cause = mf_kind ? 3'd4 : 3'd3;
      e_pc = fpc; e_flush = low_ones(EX2 + 1);
      for (int s = EX2; s >= 0; s--) begin
        if (vld[s]) begin
          e_pc = pc_of(s); e_flush = low_ones(s + 1);
          break;
        end
      end
    end else if (lands_mid()) begin
      e_take = 1; e_cause = 3'd5; e_pc = rd_pc; e_flush = low_ones(EX1 + 1);
    end else if (sw_req && vld[EX1]) begin
      e_take = 1; e_cause = sw_call ? 3'd2 : 3'd1; e_pc = pc_of(EX1);
      e_flush = low_ones(EX1 + 1);
    end
  endtask

  task automatic check(input string tag, input logic ok, input string what,
                       input logic [PCW-1:0] act, input logic [PCW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag);
    predict();
    @(posedge clk);
    #1;
    check(tag, take === e_take, "take", PCW'(take), PCW'(e_take));
    check(tag, cause === e_cause, "cause", PCW'(cause), PCW'(e_cause));
    check(tag, flush === e_flush, "flush", PCW'(flush), PCW'(e_flush));
    if (e_take) check(tag, rpc === e_pc, "pc", rpc, e_pc);
    check("R7", (flush >> (EX2 + 1)) == '0, "old-stage flush", PCW'(flush), '0);
    @(negedge clk);
  endtask

  task automatic clear();
    sw_req = 0; sw_call = 0; mf_req = 0; mf_kind = 0; rd_req = 0;
  endtask

  task automatic set_pipe(input logic [NSTG-1:0] v);
    vld = v;
    for (int i = 0; i < NSTG; i++) begin
      pcs[i*PCW +: PCW]    = 32'h1000 - 32'(i) * 32'h10;
      lens[i*LENW +: LENW] = LENW'(1 + (i % 3));
    end
    fpc = 32'h2000;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired (all requirements)");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1", take === 0 && flush === '0 && cause === 0 && rpc === '0,
          "reset outputs", PCW'(take), '0);
    rst_n = 1;
    set_pipe('1);
    predict();
    @(posedge clk); #1;
    check("R1", take === 0 && flush === '0 && cause === 0 && rpc === '0,
          "first cycle after reset", PCW'(take), '0);
    @(negedge clk);

    // R2 trap and syscall
    clear(); sw_req = 1; step("R2");
    sw_call = 1; step("R2");
    // R11 pulse ends
    clear(); step("R11");
    // R3 bubble in EX1
    set_pipe(6'b111011); sw_req = 1; step("R3");
    // R4 TLB miss and protection
    clear(); set_pipe('1); mf_req = 1; step("R4");
    mf_kind = 1; step("R4");
    // R5 fallback to EX1, then to fetch slot only
    set_pipe(6'b110111); mf_kind = 0; step("R5");
    set_pipe(6'b110011); step("R5");
    set_pipe(6'b110001); step("R5");
    // R6 nothing live at or below EX2
    set_pipe(6'b110000); step("R6");
    // R8 landing one word into a 3-word instruction (stage 2, len 3, pc 0xFE0)
    clear(); set_pipe('1); rd_req = 1; rd_pc = 32'h0FE4; step("R8");
    rd_pc = 32'h0FE8; step("R8");
    // R9 exact start and exact end are legal
    rd_pc = 32'h0FE0; step("R9");
    rd_pc = 32'h0FEC; step("R9");
    rd_pc = 32'h5000; step("R9");
    // R10 coincident requests
    rd_pc = 32'h0FE4; mf_req = 1; sw_req = 1; step("R10");
    mf_req = 0; step("R10");
    rd_pc = 32'h0FE0; step("R10");

    // Random mix (R2 R4 R5 R8 R10)
    for (int n = 0; n < 3000; n++) begin
      vld = NSTG'($urandom);
      for (int i = 0; i < NSTG; i++) begin
        pcs[i*PCW +: PCW]    = $urandom & 32'h0000_FFFC;
        lens[i*LENW +: LENW] = LENW'(1 + ($urandom % 3));
      end
      fpc     = $urandom & 32'h0FFF_FFFC;
      sw_req  = ($urandom % 3) == 0;
      sw_call = $urandom % 2;
      mf_req  = ($urandom % 4) == 0;
      mf_kind = $urandom % 2;
      rd_req  = ($urandom % 3) == 0;
      begin
        int j = $urandom % NSTG;
        rd_pc = pcs[j*PCW +: PCW] + 32'($urandom % 16);
      end
      step("R10-random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule